// File: doc/BRIEF.md
# Configurable serial data output formatter

This block takes a parallel result word of 1 to 32 valid bits, such as a conversion value with parity and a channel tag, and sends it out on one or two serial data lanes. The host loads the word together with its valid length while the block is idle. Each clock cycle with the shift enable high then moves every active lane on by one bit, MSB first. When the last bit has been shifted out, busy falls and done pulses for one cycle.

An 8-bit control register selects the frame layout. One field picks a fixed 16-bit or 32-bit framing suited to a microcontroller, with zero padding placed after the data or before it. Another picks one lane or two. A third decides how two lanes share the frame: alternating bits, or the upper half of the frame on lane 1 and the lower half on lane 0. The register comes out of reset locked, and a write takes effect only while the unlock input is high. The layout is captured when a word is loaded, so a register write made during a frame applies from the next frame on.

Top module: `sdo_formatter`

## Requirements
- R1: After reset the control register reads 0x00, busy and done are low, and both lanes are low.
- R2: A write (cfg_we high) changes the control register only when cfg_unlock is high in the same cycle. Otherwise the register keeps its value.
- R3: Control register layout: bit 6 is the microcontroller framing enable, bit 5 is right alignment, bit 4 is the half split, bit 2 is the two-lane enable, and bits 1:0 are the protocol select. Bits 7 and 3 always read 0, so writing 0xFF reads back as 0x77.
- R4: A write whose bits 1:0 are 01 or 10 leaves the protocol select unchanged. The other fields of that write still take effect, so writing 0x01 over 0x77 reads back as 0x03.
- R5: With framing disabled, the frame is the N data bits, MSB first, where N is load_len. Bit 5 has no effect in this case.
- R6: With framing enabled, the frame is 16 bits when N ≤ 16 and 32 bits otherwise. With bit 5 at 0 the data is sent first and trailing zeros fill the frame. With bit 5 at 1 leading zeros are sent first and the data follows.
- R7: With bit 2 at 0, all frame bits leave on sdo0, one per shift, and sdo1 stays low.
- R8: With bit 2 at 1, and not both bit 6 and bit 4 set, sdo1 carries frame bits F-1, F-3, … and sdo0 carries F-2, F-4, …, where F is the frame length. The frame takes ceil(F/2) shifts, and sdo0 outputs 0 on a final shift where it has no bit left.
- R9: With bits 6, 4 and 2 all at 1, sdo1 carries the upper F/2 frame bits and sdo0 carries the lower F/2 bits, each MSB first, over F/2 shifts.
- R10: A load is accepted only while idle. From the next cycle, busy is high and the first bits are on the lanes. A cycle with shift_en high advances the lanes by one bit, and a cycle with it low holds them. The edge that shifts out the last bit drops busy and raises done for exactly one cycle. A load while busy is ignored. Both lanes are low while idle.
- R11: The frame layout is taken from the control register at load time. A register write during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unlock | input | 1 | Write unlock for the control register |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| load | input | 1 | Load strobe for a new word |
| load_data | input | 32 | Result word, valid bits in the low N positions |
| load_len | input | 6 | Number of valid bits N (1 to 32) |
| shift_en | input | 1 | Advance the lanes by one bit |
| sdo0 | output | 1 | Serial lane 0 |
| sdo1 | output | 1 | Serial lane 1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
Words are sent with framing off at lengths 1, 11, 12 and 32. With framing on, the bench uses lengths of 12, 16 and 20, left- and right-aligned, which shows whether the frame rounds up to 16 or 32 bits and on which side the zeros land. The two-lane cases use odd and even lengths, and the half-split cases use 10, 20 and 32 bits, which separates the alternating split from the half split and shows the zero fill on the shorter lane. Gapped shift enables, a load issued mid-frame and a register write mid-frame confirm that the lanes hold between shifts and that a running frame is not disturbed.

// File: rtl/sdo_pkg.sv
package sdo_pkg;

    localparam int DATA_W = 32;
    localparam int HALF   = DATA_W / 2;
    localparam int LEN_W  = $clog2(DATA_W + 1);
    localparam int CFG_W  = 8;

    typedef struct packed {
        logic       rsv7;
        logic       uc_mode;
        logic       right_align;
        logic       half_split;
        logic       rsv3;
        logic       two_lane;
        logic [1:0] proto;
    } out_cfg_t;

    typedef enum logic [1:0] {
        SPLIT_ONE  = 2'd0,
        SPLIT_ALT  = 2'd1,
        SPLIT_HALF = 2'd2
    } split_e;

    typedef struct packed {
        logic [DATA_W-1:0] lane1;
        logic [DATA_W-1:0] lane0;
        logic [LEN_W-1:0]  beats;
        split_e            split;
    } frame_t;

    function automatic logic proto_ok(input logic [1:0] p);
        return (p == 2'b00) || (p == 2'b11);
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input out_cfg_t c,
                                                   input logic [LEN_W-1:0] n);
        if (!c.uc_mode)
            return n;
        return (n <= LEN_W'(HALF)) ? LEN_W'(HALF) : LEN_W'(DATA_W);
    endfunction

    function automatic split_e pick_split(input out_cfg_t c);
        if (!c.two_lane)
            return SPLIT_ONE;
        if (c.uc_mode && c.half_split)
            return SPLIT_HALF;
        return SPLIT_ALT;
    endfunction

endpackage

// File: rtl/sdo_cfg_reg.sv
module sdo_cfg_reg
    import sdo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             unlock,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output out_cfg_t         cfg
);

    out_cfg_t nxt;

    always_comb begin
        nxt      = out_cfg_t'(wdata);
        nxt.rsv7 = 1'b0;
        nxt.rsv3 = 1'b0;
        if (!proto_ok(wdata[1:0]))
            nxt.proto = cfg.proto;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (we && unlock)
            cfg <= nxt;
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(we && unlock) |=> $stable(cfg)); // R2

    AST_BAD_PROTO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (we && unlock && !proto_ok(wdata[1:0])) |=> cfg.proto == $past(cfg.proto)); // R4

    AST_GOOD_PROTO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (we && unlock && proto_ok(wdata[1:0])) |=> cfg.proto == $past(wdata[1:0])); // R4

endmodule

// File: rtl/sdo_frame_builder.sv
module sdo_frame_builder
    import sdo_pkg::*;
(
    input  out_cfg_t          cfg,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LEN_W-1:0]  load_len,
    output frame_t            frm
);

    logic [LEN_W-1:0]  n;
    logic [LEN_W-1:0]  f;
    logic [LEN_W-1:0]  h;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] top;

    always_comb begin
        n = load_len;
        if (n == '0)
            n = LEN_W'(1);
        else if (n > LEN_W'(DATA_W))
            n = LEN_W'(DATA_W);
        f    = frame_len(cfg, n);
        h    = f >> 1;
        mask = {DATA_W{1'b1}} >> (DATA_W - int'(n));
        word = load_data & mask;
        if (cfg.uc_mode && !cfg.right_align)
            word = word << (int'(f) - int'(n));
        top = word << (DATA_W - int'(f));

        frm       = '0;
        frm.split = pick_split(cfg);
        case (frm.split)
            SPLIT_ONE: begin
                frm.lane0 = top;
                frm.beats = f;
            end
            SPLIT_ALT: begin
                for (int i = 0; i < HALF; i++) begin
                    frm.lane1[DATA_W-1-i] = top[DATA_W-1-2*i];
                    frm.lane0[DATA_W-1-i] = top[DATA_W-2-2*i];
                end
                frm.beats = LEN_W'((int'(f) + 1) / 2);
            end
            default: begin
                frm.lane1 = top & ~({DATA_W{1'b1}} >> int'(h));
                frm.lane0 = top << int'(h);
                frm.beats = h;
            end
        endcase
    end

endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter
    import sdo_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frm,
    input  logic   shift_en,
    output logic   sdo0,
    output logic   sdo1,
    output logic   busy,
    output logic   done
);

    logic [DATA_W-1:0] sh0;
    logic [DATA_W-1:0] sh1;
    logic [LEN_W-1:0]  cnt;
    split_e            split_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh0     <= '0;
            sh1     <= '0;
            cnt     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            split_q <= SPLIT_ONE;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (shift_en) begin
                    sh0 <= sh0 << 1;
                    sh1 <= sh1 << 1;
                    cnt <= cnt - LEN_W'(1);
                    if (cnt == LEN_W'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else if (load) begin
                sh0     <= frm.lane0;
                sh1     <= frm.lane1;
                cnt     <= frm.beats;
                split_q <= frm.split;
                busy    <= 1'b1;
            end
        end
    end

    assign sdo0 = busy & sh0[DATA_W-1];
    assign sdo1 = busy & sh1[DATA_W-1];

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && load) |=> busy); // R10

    AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (busy && !shift_en) |=> (busy && $stable(sh0) && $stable(sh1) && $stable(cnt))); // R10

    AST_ONE_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (busy && split_q == SPLIT_ONE) |-> !sdo1); // R7

    AST_BEATS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (!busy && load) |-> frm.beats != '0); // R5

endmodule

// File: rtl/sdo_formatter.sv
module sdo_formatter
    import sdo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_unlock,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              shift_en,
    output logic              sdo0,
    output logic              sdo1,
    output logic              busy,
    output logic              done
);

    out_cfg_t cfg;
    frame_t   frm;

    sdo_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .unlock (cfg_unlock),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .cfg    (cfg)
    );

    sdo_frame_builder u_build (
        .cfg       (cfg),
        .load_data (load_data),
        .load_len  (load_len),
        .frm       (frm)
    );

    sdo_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frm      (frm),
        .shift_en (shift_en),
        .sdo0     (sdo0),
        .sdo1     (sdo1),
        .busy     (busy),
        .done     (done)
    );

    assign cfg_rdata = cfg;

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[7] == 1'b0) && (cfg_rdata[3] == 1'b0)); // R3

    AST_IDLE_LANES_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!sdo0 && !sdo1 && done)); // R10

endmodule

// File: tb/tb_sdo_formatter.sv
module tb_sdo_formatter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_unlock = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        load = 1'b0;
    logic [31:0] load_data = '0;
    logic [5:0]  load_len = '0;
    logic        shift_en = 1'b0;
    logic        sdo0, sdo1, busy, done;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    bit       q0[$];
    bit       q1[$];
    bit       m_busy = 1'b0;
    bit       m_done = 1'b0;
    bit [7:0] m_cfg = '0;

    always #4 clk = ~clk;

    sdo_formatter dut (
        .clk(clk), .rst(rst), .cfg_unlock(cfg_unlock), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .load(load),
        .load_data(load_data), .load_len(load_len), .shift_en(shift_en),
        .sdo0(sdo0), .sdo1(sdo1), .busy(busy), .done(done)
    );

    task automatic build(input logic [31:0] d, input int len, input bit [7:0] c);
        bit fb[$];
        int f;
        bit uc, ra, hs, two;
        uc = c[6]; ra = c[5]; hs = c[4]; two = c[2];
        q0.delete(); q1.delete();
        f = uc ? ((len <= 16) ? 16 : 32) : len;
        if (uc && ra) repeat (f - len) fb.push_back(1'b0);
        for (int i = len - 1; i >= 0; i--) fb.push_back(d[i]);
        if (uc && !ra) repeat (f - len) fb.push_back(1'b0);
        for (int i = 0; i < f; i++) begin
            if (!two) q0.push_back(fb[i]);
            else if (uc && hs) begin
                if (i < f / 2) q1.push_back(fb[i]); else q0.push_back(fb[i]);
            end else begin
                if (i % 2 == 0) q1.push_back(fb[i]); else q0.push_back(fb[i]);
            end
        end
        while (q0.size() < q1.size()) q0.push_back(1'b0);
        while (q1.size() < q0.size()) q1.push_back(1'b0);
    endtask

    always @(posedge clk) begin
        bit [7:0] nc;
        if (rst) begin
            m_cfg = '0; m_busy = 1'b0; m_done = 1'b0;
            q0.delete(); q1.delete();
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                if (shift_en) begin
                    void'(q0.pop_front());
                    void'(q1.pop_front());
                    if (q0.size() == 0) begin
                        m_busy = 1'b0;
                        m_done = 1'b1;
                    end
                end
            end else if (load) begin
                build(load_data, int'(load_len), m_cfg);
                m_busy = 1'b1;
            end
            if (cfg_we && cfg_unlock) begin
                nc = cfg_wdata & 8'h77;
                if (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10)
                    nc[1:0] = m_cfg[1:0];
                m_cfg = nc;
            end
        end
    end

    always @(negedge clk) begin
        bit e0, e1;
        if (!rst) begin
            e0 = m_busy ? q0[0] : 1'b0;
            e1 = m_busy ? q1[0] : 1'b0;
            checks++;
            if (sdo0 !== e0 || sdo1 !== e1 || busy !== m_busy || done !== m_done ||
                cfg_rdata !== m_cfg) begin
                errors++;
                $display("FAIL %s: sdo1/sdo0/busy/done/cfg act=%b%b%b%b/%h exp=%b%b%b%b/%h",
                         cur_req, sdo1, sdo0, busy, done, cfg_rdata,
                         e1, e0, m_busy, m_done, m_cfg);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v, input bit unl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_unlock = unl; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_unlock = 1'b0;
    endtask

    task automatic frame(input logic [31:0] d, input int len, input bit gap,
                         input bit mid, input logic [7:0] midv);
        @(negedge clk);
        load = 1'b1; load_data = d; load_len = len[5:0];
        @(negedge clk);
        load = 1'b0;
        for (int k = 0; k < 80; k++) begin
            shift_en = gap ? (k % 3 != 2) : 1'b1;
            if (k == 1) begin
                load = 1'b1; load_data = ~d; load_len = 6'd5;
            end else load = 1'b0;
            if (mid && k == 2) begin
                cfg_we = 1'b1; cfg_unlock = 1'b1; cfg_wdata = midv;
            end else begin
                cfg_we = 1'b0; cfg_unlock = 1'b0;
            end
            @(negedge clk);
            if (!m_busy) break;
        end
        shift_en = 1'b0; load = 1'b0; cfg_we = 1'b0; cfg_unlock = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk(cfg_rdata == 8'h00, "R1 cfg", int'(cfg_rdata), 0);
        chk(!busy && !done && !sdo0 && !sdo1, "R1 outputs",
            int'({busy, done, sdo1, sdo0}), 0);

        cur_req = "R2";
        wr(8'h44, 1'b0);
        chk(cfg_rdata == 8'h00, "R2 locked write", int'(cfg_rdata), 0);

        cur_req = "R3";
        wr(8'hFF, 1'b1);
        chk(cfg_rdata == 8'h77, "R3 reserved zero", int'(cfg_rdata), 'h77);

        cur_req = "R4";
        wr(8'h01, 1'b1);
        chk(cfg_rdata == 8'h03, "R4 proto 01 kept", int'(cfg_rdata), 'h03);
        wr(8'h02, 1'b1);
        chk(cfg_rdata == 8'h03, "R4 proto 10 kept", int'(cfg_rdata), 'h03);
        wr(8'h00, 1'b1);
        chk(cfg_rdata == 8'h00, "R4 proto 00 taken", int'(cfg_rdata), 0);

        cur_req = "R5";
        frame(32'h0000_0ABC, 12, 1'b0, 1'b0, 8'h00);
        frame(32'h0000_0001, 1, 1'b0, 1'b0, 8'h00);
        frame(32'hDEAD_BEEF, 32, 1'b1, 1'b0, 8'h00);
        wr(8'h20, 1'b1);
        frame(32'h0000_05A5, 11, 1'b0, 1'b0, 8'h00);

        cur_req = "R6";
        wr(8'h40, 1'b1);
        frame(32'h0000_0ABC, 12, 1'b0, 1'b0, 8'h00);
        frame(32'h0001_2345, 20, 1'b1, 1'b0, 8'h00);
        wr(8'h60, 1'b1);
        frame(32'h0000_0ABC, 12, 1'b0, 1'b0, 8'h00);
        frame(32'h0001_2345, 20, 1'b0, 1'b0, 8'h00);
        frame(32'h0000_FFFF, 16, 1'b1, 1'b0, 8'h00);

        cur_req = "R7";
        wr(8'h50, 1'b1);
        frame(32'h0000_03C3, 10, 1'b0, 1'b0, 8'h00);
        wr(8'h10, 1'b1);
        frame(32'h0000_1F0F, 13, 1'b1, 1'b0, 8'h00);

        cur_req = "R8";
        wr(8'h04, 1'b1);
        frame(32'h0000_1555, 13, 1'b0, 1'b0, 8'h00);
        frame(32'h0000_BEEF, 16, 1'b1, 1'b0, 8'h00);
        wr(8'h14, 1'b1);
        frame(32'h0000_007F, 7, 1'b0, 1'b0, 8'h00);
        wr(8'h44, 1'b1);
        frame(32'h0000_02AB, 10, 1'b0, 1'b0, 8'h00);

        cur_req = "R9";
        wr(8'h54, 1'b1);
        frame(32'h0000_02AB, 10, 1'b0, 1'b0, 8'h00);
        frame(32'hCAFE_F00D, 32, 1'b1, 1'b0, 8'h00);
        wr(8'h74, 1'b1);
        frame(32'h000A_BCDE, 20, 1'b0, 1'b0, 8'h00);

        cur_req = "R10";
        wr(8'h00, 1'b1);
        frame(32'h0000_0093, 8, 1'b1, 1'b0, 8'h00);

        cur_req = "R11";
        frame(32'h000C_3A5F, 20, 1'b0, 1'b1, 8'h54);
        chk(cfg_rdata == 8'h54, "R11 mid write stored", int'(cfg_rdata), 'h54);
        frame(32'h000C_3A5F, 20, 1'b0, 1'b0, 8'h00);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule